// File: doc/BRIEF.md
# Latched BCD Seven-Segment Digit Driver

This block drives a single seven-segment digit from a 4-bit BCD code. A code register captures the BCD input on every clock edge while the load enable is high. When the load enable drops, the register keeps its value and ignores later changes at the input. The held code is decoded to the segment pattern for digits 0 to 9. The pattern is forced dark when the blanking input is high, and also for any code from 10 to 15.

After decoding, a phase control can invert the whole 7-bit segment word. With phase low the block drives common-cathode LEDs, and with phase high it drives common-anode LEDs. For a liquid-crystal display, the same square wave must reach the phase control and the display's common backplane. The block can produce this square wave itself: a clock divider toggles every `HALF_PERIOD` clocks. A mode input chooses between this internal wave and the external phase pin. The phase that is applied to the segments is registered together with the segments and appears on `backplane_out`. Because of this, a lit segment is always opposite to the backplane in every cycle.

Top module: `seg_digit_drv`

## Requirements
- R1: While `rst_n` is low at a clock edge, the code register clears to 0, the divider and its wave clear to 0, and `seg_out` and `backplane_out` read 0 after that edge.
- R2: On a rising edge with `load_en` high, the code register takes `bcd_in`. On an edge with `load_en` low, it keeps its value, and changes on `bcd_in` have no effect on `seg_out`.
- R3: `seg_out` bit i drives segment i in the order a=0, b=1, c=2, d=3, e=4, f=5, g=6. With phase 0, codes 0 to 9 give the hex patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R4: Held codes 10 to 15 give the all-dark pattern 00 before phase inversion.
- R5: `blank_in` high gives the all-dark pattern 00 before phase inversion, whatever code is held.
- R6: With `auto_phase` low, `inv_in` high inverts all seven outputs bitwise. A dark digit then reads 7F.
- R7: With `auto_phase` high, the applied phase is the internal square wave. This wave changes level once every `HALF_PERIOD` clock cycles.
- R8: `backplane_out` always equals the phase that was applied to `seg_out` in the same cycle. So `seg_out` XOR {7{`backplane_out`}} is always the uninverted pattern.
- R9: A change on `blank_in`, `inv_in` or `auto_phase` reaches the outputs one clock after the edge that samples it. A code loaded at an edge appears on `seg_out` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bcd_in | input | 4 | BCD code, weights 8-4-2-1 from bit 3 down |
| load_en | input | 1 | High: register follows bcd_in; low: code held |
| blank_in | input | 1 | High forces the digit dark |
| inv_in | input | 1 | External phase; high inverts all segments |
| auto_phase | input | 1 | High selects the internal square wave as phase |
| seg_out | output | 7 | Registered segment drive, a in bit 0 |
| backplane_out | output | 1 | Registered phase, for the display backplane |

## Verification
A wrong held code shows up as a wrong glyph on `seg_out` one edge after the load. A code register that leaks while closed shows as a new glyph one cycle after `bcd_in` changes. A faulty divider count shows as a backplane half-period that differs from `HALF_PERIOD`. A phase that goes out of step between segments and backplane shows up in the first cycle as a segment word whose XOR with the backplane is not the expected glyph. The bench measures each of these at the ports, on the exact cycle where the change is due.

// File: rtl/seg_pkg.sv
// Package: shared widths, segment word type and digit glyph lookup.
// Assumes segment a sits in bit 0 and g in bit 6.
package seg_pkg;
    localparam int CODE_W = 4;
    localparam int SEG_N  = 7;
    localparam int MAX_DIGIT = 9;

    typedef logic [CODE_W-1:0] bcd_code_t;
    typedef logic [SEG_N-1:0]  seg_word_t;

    localparam seg_word_t SEG_DARK = '0;

    // Glyph for one held code; anything above nine is dark.
    function automatic seg_word_t glyph_of(input bcd_code_t code);
        seg_word_t w;
        case (code)
            4'd0:    w = 7'h3F;
            4'd1:    w = 7'h06;
            4'd2:    w = 7'h5B;
            4'd3:    w = 7'h4F;
            4'd4:    w = 7'h66;
            4'd5:    w = 7'h6D;
            4'd6:    w = 7'h7D;
            4'd7:    w = 7'h07;
            4'd8:    w = 7'h7F;
            4'd9:    w = 7'h6F;
            default: w = SEG_DARK;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/seg_code_hold.sv
// Module: code register. It loads the BCD input on edges where load_en is
// high and holds it otherwise. Assumes the input meets setup and hold
// relative to the edge where load_en is sampled low.
module seg_code_hold
    import seg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bcd_code_t bcd_in,
    input  logic      load_en,
    output bcd_code_t code_q
);
    // Capture or hold the code; reset clears it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= '0;
        else if (load_en) code_q <= bcd_in;
    end

    // R2: a closed register keeps its value.
    p_hold_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(code_q)) else $error("code changed while closed");

    // R2: an open register takes the input.
    p_load_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> code_q == $past(bcd_in)) else $error("code not loaded");
endmodule

// File: rtl/seg_glyph_dec.sv
// Module: combinational decoder from the held code to the uninverted segment
// pattern. The blanking input and codes above nine give a dark pattern.
module seg_glyph_dec
    import seg_pkg::*;
(
    input  bcd_code_t code,
    input  logic      blank,
    output seg_word_t pattern
);
    // Pick the glyph, or dark when blanked.
    always_comb begin
        pattern = blank ? SEG_DARK : glyph_of(code);
    end
endmodule

// File: rtl/seg_phase_div.sv
// Module: square-wave generator. The wave toggles once every HALF_PERIOD
// clocks after reset. Assumes HALF_PERIOD >= 2.
module seg_phase_div #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic wave
);
    localparam int CW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic          wave_q;

    // Count cycles in the current half period and flip the wave at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            wave_q <= ~wave_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign wave = wave_q;

    // R7: the wave only changes after a full half period has been counted.
    p_wave_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wave_q) |-> $past(cnt_q) == LAST) else $error("early wave flip");

    // R7: the counter never leaves its range.
    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST) else $error("counter out of range");
endmodule

// File: rtl/seg_digit_drv.sv
// Module: top level of the single-digit driver. It holds the code, decodes
// it, selects the phase and registers the segment word and the backplane
// together. When HAS_PHASE_GEN is 0, the internal wave is tied low.
module seg_digit_drv #(
    parameter int HALF_PERIOD   = 4,
    parameter bit HAS_PHASE_GEN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] bcd_in,
    input  logic       load_en,
    input  logic       blank_in,
    input  logic       inv_in,
    input  logic       auto_phase,
    output logic [6:0] seg_out,
    output logic       backplane_out
);
    import seg_pkg::*;

    bcd_code_t code_q;
    seg_word_t pattern;
    seg_word_t seg_q;
    logic      wave;
    logic      phase_sel;
    logic      bp_q;

    seg_code_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .bcd_in  (bcd_in),
        .load_en (load_en),
        .code_q  (code_q)
    );

    seg_glyph_dec u_dec (
        .code    (code_q),
        .blank   (blank_in),
        .pattern (pattern)
    );

    generate
        if (HAS_PHASE_GEN) begin : g_div
            seg_phase_div #(.HALF_PERIOD(HALF_PERIOD)) u_div (
                .clk   (clk),
                .rst_n (rst_n),
                .wave  (wave)
            );
        end else begin : g_nodiv
            assign wave = 1'b0;
        end
    endgenerate

    // Choose the phase source.
    always_comb begin
        phase_sel = auto_phase ? wave : inv_in;
    end

    // Register the segments and the phase side by side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= SEG_DARK;
            bp_q  <= 1'b0;
        end else begin
            seg_q <= pattern ^ {SEG_N{phase_sel}};
            bp_q  <= phase_sel;
        end
    end

    assign seg_out       = seg_q;
    assign backplane_out = bp_q;

    // R5: blanking darkens the digit one clock later.
    p_blank_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blank_in |=> (seg_out ^ {SEG_N{backplane_out}}) == SEG_DARK)
        else $error("blank not dark");

    // R4: a held code above nine darkens the digit.
    p_illegal_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q > 4'd9) |=> (seg_out ^ {SEG_N{backplane_out}}) == SEG_DARK)
        else $error("illegal code lit");

    // R6: in external mode the backplane follows the phase pin.
    p_ext_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_phase |=> backplane_out == $past(inv_in))
        else $error("external phase not applied");

    // R8: in internal mode the backplane follows the generated wave.
    p_int_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        auto_phase |=> backplane_out == $past(wave))
        else $error("internal phase not applied");
endmodule

// File: tb/seg_digit_drv_tb.sv
`timescale 1ns/1ps
module seg_digit_drv_tb;
    localparam int HP = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] bcd_in;
    logic       load_en, blank_in, inv_in, auto_phase;
    logic [6:0] seg_out;
    logic       backplane_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    seg_digit_drv #(.HALF_PERIOD(HP), .HAS_PHASE_GEN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .load_en(load_en),
        .blank_in(blank_in), .inv_in(inv_in), .auto_phase(auto_phase),
        .seg_out(seg_out), .backplane_out(backplane_out)
    );

    function automatic logic [6:0] exp_glyph(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
            9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance n rising edges and settle at the following falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; bcd_in = 4'd9; load_en = 1'b1;
        blank_in = 1'b0; inv_in = 1'b1; auto_phase = 1'b0;
        step(3);
        chk("R1 seg", {1'b0, seg_out}, 8'h00);
        chk("R1 bp", {7'b0, backplane_out}, 8'h00);
        bcd_in = 4'd0; inv_in = 1'b0;
        rst_n = 1'b1;
        step(2);
        chk("R1 code zero after reset", {1'b0, seg_out}, {1'b0, exp_glyph(0)});
    endtask

    task automatic t_digits();
        for (int d = 0; d < 10; d++) begin
            bcd_in = 4'(d); load_en = 1'b1;
            step(2);
            chk($sformatf("R3 digit %0d", d), {1'b0, seg_out}, {1'b0, exp_glyph(d)});
        end
    endtask

    task automatic t_illegal();
        for (int d = 10; d < 16; d++) begin
            bcd_in = 4'(d); inv_in = 1'b0;
            step(2);
            chk($sformatf("R4 code %0d", d), {1'b0, seg_out}, 8'h00);
            inv_in = 1'b1;
            step(1);
            chk($sformatf("R4 code %0d inverted", d), {1'b0, seg_out}, 8'h7F);
        end
        inv_in = 1'b0;
    endtask

    task automatic t_blank();
        bcd_in = 4'd8; blank_in = 1'b1;
        step(2);
        chk("R5 blank on 8", {1'b0, seg_out}, 8'h00);
        inv_in = 1'b1;
        step(1);
        chk("R6 blank inverted", {1'b0, seg_out}, 8'h7F);
        blank_in = 1'b0; inv_in = 1'b0;
        step(1);
        chk("R5 unblank", {1'b0, seg_out}, {1'b0, exp_glyph(8)});
    endtask

    task automatic t_invert();
        for (int d = 0; d < 10; d++) begin
            bcd_in = 4'(d); inv_in = 1'b1;
            step(2);
            chk($sformatf("R6 inv digit %0d", d), {1'b0, seg_out}, {1'b0, ~exp_glyph(d)});
            chk("R8 bp ext", {7'b0, backplane_out}, 8'h01);
        end
        inv_in = 1'b0;
        step(1);
    endtask

    task automatic t_hold();
        bcd_in = 4'd7; load_en = 1'b1;
        step(1);
        load_en = 1'b0;
        bcd_in = 4'd2;
        step(3);
        chk("R2 held 7", {1'b0, seg_out}, {1'b0, exp_glyph(7)});
        bcd_in = 4'd12;
        step(2);
        chk("R2 held ignores 12", {1'b0, seg_out}, {1'b0, exp_glyph(7)});
        load_en = 1'b1; bcd_in = 4'd2;
        step(2);
        chk("R2 reopen 2", {1'b0, seg_out}, {1'b0, exp_glyph(2)});
    endtask

    task automatic t_latency();
        bcd_in = 4'd5; load_en = 1'b1;
        step(2);
        load_en = 1'b0;
        blank_in = 1'b1;
        chk("R9 before edge", {1'b0, seg_out}, {1'b0, exp_glyph(5)});
        step(1);
        chk("R9 blank after one edge", {1'b0, seg_out}, 8'h00);
        blank_in = 1'b0; load_en = 1'b1; bcd_in = 4'd1;
        step(1);
        chk("R9 code not yet shown", {1'b0, seg_out}, {1'b0, exp_glyph(5)});
        step(1);
        chk("R9 code one edge after load", {1'b0, seg_out}, {1'b0, exp_glyph(1)});
    endtask

    task automatic t_auto();
        int since = 0;
        int flips = 0;
        logic prev_bp;
        bcd_in = 4'd3; load_en = 1'b1; inv_in = 1'b0;
        step(2);
        auto_phase = 1'b1;
        step(1);
        prev_bp = backplane_out;
        for (int c = 0; c < 8 * HP; c++) begin
            step(1);
            since++;
            chk("R8 seg vs bp", {1'b0, seg_out ^ {7{backplane_out}}}, {1'b0, exp_glyph(3)});
            if (backplane_out !== prev_bp) begin
                if (flips > 0) chk("R7 half period", 8'(since), 8'(HP));
                flips++;
                since = 0;
                prev_bp = backplane_out;
            end
        end
        chk("R7 wave toggled", 8'(flips >= 6), 8'h01);
        auto_phase = 1'b0;
        step(1);
        chk("R8 back to external", {7'b0, backplane_out}, 8'h00);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_digits();
        t_illegal();
        t_blank();
        t_invert();
        t_hold();
        t_latency();
        t_auto();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule